// File: doc/BRIEF.md
# E1/T1 Transmit Position Marker Generator

This block runs a bit-position counter alongside a serial E1 or T1 transmit stream and decodes from it three strobes that frame the data for neighbouring logic. Each strobe is held for one whole bit period. A multiframe-start strobe flags the first bit of every multiframe. A signaling strobe flags either every bit of the time slots chosen by a per-slot enable word, or, in T1 with robbed-bit signaling, only the robbed bits. A data-link strobe flags the enabled Sa bits in E1 or the extended-superframe data-link framing bits in T1.

The position advances by one bit on every clock cycle in which the bit-clock enable is high. The enable arrives at 2.048 MHz for E1 and 1.544 MHz for T1. All configuration arrives on plain level inputs and reaches the strobes combinationally. A synchronous reset, or any change of the E1/T1 select, puts the counter back at the first bit of frame 1.

Top module: `txmark_gen`

## Requirements
- R1: `mf_begin` is high for exactly the bit period of the first bit of each multiframe. In E1 that is bit 1 of slot 0 of frame 1. In T1 it is the framing bit of frame 1. It is low for every other bit.
- R2: In E1 mode (`mode_t1`=0), frames are numbered 1 to 16 and hold 32 slots of 8 bits, with bit 1 sent first. `dl_mark` can only be high in slot 0 of even-numbered frames, at bit positions 4 to 8.
- R3: In E1 mode, bit k of `sa_en` (k = 0 to 4) enables the Sa bit at position k+4 of slot 0. `dl_mark` is high at that position exactly when that bit is set.
- R4: In T1 mode (`mode_t1`=1), frames are numbered 1 to 24. Each frame is one framing bit followed by 24 channels of 8 bits. `dl_mark` is high only when `esf_sel`=1, and then exactly on the framing bit of odd-numbered frames. That is one bit in every two frames (4 kHz).
- R5: With robbed-bit signaling off, or in E1, `sig_mark` is high for all 8 bits of slot/channel i, in every frame, exactly when `slot_en[i]` is set. In T1 only bits 0 to 23 are used. `sig_mark` is low on T1 framing bits.
- R6: In T1 mode with `rbs_en`=1, `sig_mark` is high exactly on bit 8 of every channel in frames 6, 12, 18 and 24. `slot_en` then has no effect.
- R7: The position advances by exactly one bit on each clock cycle with `bit_en`=1, and holds while `bit_en`=0. A multiframe is 4096 bits in E1 and 4632 bits in T1.
- R8: After a synchronous reset (`rst`=1), the position is the first bit of frame 1, so `mf_begin` is high until the first `bit_en`.
- R9: A change of `mode_t1` restarts the position at the first bit of frame 1 on the following clock edge. Any `bit_en` in that cycle is absorbed.
- R10: In E1 mode, `esf_sel` and `rbs_en` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable, one cycle per transmitted bit |
| mode_t1 | input | 1 | 0 = E1 framing, 1 = T1 framing |
| esf_sel | input | 1 | T1 extended superframe data-link marking enable |
| rbs_en | input | 1 | T1 robbed-bit signaling marker select |
| slot_en | input | 32 | Per-slot signaling marker enable, bit i for slot/channel i |
| sa_en | input | 5 | Sa4..Sa8 enables, bit k for Sa(k+4) |
| mf_begin | output | 1 | Multiframe first-bit strobe |
| sig_mark | output | 1 | Signaling position strobe |
| dl_mark | output | 1 | Data-link position strobe |

## Verification
The bench targets the positions where the two framings differ. These are the T1 framing bit, which pushes every channel one bit later, and the alternation of frame parity, which decides both the E1 Sa frames and the T1 data-link frames. A counter that wrapped the T1 frame at 192 bits would drift the robbed-bit and data-link strobes by one bit per frame. A parity decode taken from the wrong frame numbering would mark the alignment-frame slot 0 instead of the Sa bits. Single-bit `sa_en` patterns expose a swapped Sa enable order. A mode switch or reset in mid-multiframe exposes a counter that keeps its old count or misses the restart strobe. Random gaps in `bit_en` expose a counter that moves without an enable.

// File: rtl/txm_pkg.sv
package txm_pkg;

  localparam int unsigned BITS_PER_SLOT = 8;
  localparam int unsigned E1_SLOTS      = 32;
  localparam int unsigned E1_MF_FRAMES  = 16;
  localparam int unsigned T1_CHANS      = 24;
  localparam int unsigned T1_MF_FRAMES  = 24;
  localparam int unsigned ROB_EVERY     = 6;
  localparam int unsigned SA_COUNT      = 5;
  localparam int unsigned SA_FIRST0     = 3;  // zero-based bit index of Sa4

  typedef struct packed {
    logic mf;
    logic sig;
    logic dl;
  } marks_t;

  // frame0 is zero-based; true for the last frame of each group of 'every'
  function automatic logic rob_frame(input int unsigned frame0,
                                     input int unsigned every);
    return ((frame0 + 1) % every) == 0;
  endfunction

  // true when bit0 lies in the Sa window and its enable is set
  function automatic logic sa_hit(input int unsigned bit0,
                                  input logic [SA_COUNT-1:0] en,
                                  input int unsigned first0);
    logic r;
    r = 1'b0;
    for (int unsigned k = 0; k < SA_COUNT; k++) begin
      if (bit0 == first0 + k) r = en[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/txm_pos_counter.sv
module txm_pos_counter
  import txm_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = BITS_PER_SLOT,
  parameter int unsigned N_E1_SLOTS = E1_SLOTS,
  parameter int unsigned N_E1_FRMS  = E1_MF_FRAMES,
  parameter int unsigned N_T1_CHANS = T1_CHANS,
  parameter int unsigned N_T1_FRMS  = T1_MF_FRAMES,
  localparam int unsigned MAX_SLOTS = (N_E1_SLOTS > N_T1_CHANS) ? N_E1_SLOTS : N_T1_CHANS,
  localparam int unsigned MAX_FRMS  = (N_E1_FRMS > N_T1_FRMS) ? N_E1_FRMS : N_T1_FRMS,
  localparam int unsigned BIT_W     = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS),
  localparam int unsigned FRM_W     = $clog2(MAX_FRMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              t1,          // framing in force
  input  logic              restart,     // mode change seen
  input  logic              restart_t1,  // framing to restart in
  output logic [BIT_W-1:0]  bit_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [FRM_W-1:0]  frame_q,
  output logic              fbit_q,
  output logic              frame_end,
  output logic              mf_end
);

  localparam logic [BIT_W-1:0]  BIT_LAST     = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] E1_SLOT_LAST = SLOT_W'(N_E1_SLOTS - 1);
  localparam logic [SLOT_W-1:0] T1_SLOT_LAST = SLOT_W'(N_T1_CHANS - 1);
  localparam logic [FRM_W-1:0]  E1_FRM_LAST  = FRM_W'(N_E1_FRMS - 1);
  localparam logic [FRM_W-1:0]  T1_FRM_LAST  = FRM_W'(N_T1_FRMS - 1);

  logic last_bit, last_slot, last_frame;

  always_comb begin
    last_bit   = (bit_q == BIT_LAST);
    last_slot  = (slot_q == (t1 ? T1_SLOT_LAST : E1_SLOT_LAST));
    last_frame = (frame_q == (t1 ? T1_FRM_LAST : E1_FRM_LAST));
    frame_end  = bit_en && !fbit_q && last_bit && last_slot;
    mf_end     = frame_end && last_frame;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bit_q   <= '0;
      slot_q  <= '0;
      frame_q <= '0;
      fbit_q  <= restart_t1;
    end else if (bit_en) begin
      if (fbit_q) begin
        fbit_q <= 1'b0;
      end else if (last_bit) begin
        bit_q <= '0;
        if (last_slot) begin
          slot_q  <= '0;
          frame_q <= last_frame ? '0 : frame_q + 1'b1;
          fbit_q  <= t1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/txm_e1_decode.sv
module txm_e1_decode
  import txm_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = BITS_PER_SLOT,
  parameter int unsigned N_SLOTS    = E1_SLOTS,
  parameter int unsigned BIT_W      = 3,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned FRM_W      = 5
) (
  input  logic [BIT_W-1:0]    bit_q,
  input  logic [SLOT_W-1:0]   slot_q,
  input  logic [FRM_W-1:0]    frame_q,
  input  logic [N_SLOTS-1:0]  slot_en,
  input  logic [SA_COUNT-1:0] sa_en,
  output marks_t              marks
);

  logic at_slot0;
  logic sa_frame;

  always_comb begin
    at_slot0  = (slot_q == '0);
    sa_frame  = frame_q[0];          // zero-based odd = no alignment word
    marks.mf  = at_slot0 && (bit_q == '0) && (frame_q == '0);
    marks.sig = slot_en[slot_q];
    marks.dl  = at_slot0 && sa_frame && sa_hit(32'(bit_q), sa_en, SA_FIRST0);
  end

endmodule

// File: rtl/txm_t1_decode.sv
module txm_t1_decode
  import txm_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = BITS_PER_SLOT,
  parameter int unsigned N_CHANS    = T1_CHANS,
  parameter int unsigned ROB_PERIOD = ROB_EVERY,
  parameter int unsigned BIT_W      = 3,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned FRM_W      = 5
) (
  input  logic [BIT_W-1:0]   bit_q,
  input  logic [SLOT_W-1:0]  slot_q,
  input  logic [FRM_W-1:0]   frame_q,
  input  logic               fbit_q,
  input  logic [N_CHANS-1:0] chan_en,
  input  logic               esf_sel,
  input  logic               rbs_en,
  output marks_t             marks
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic robbed_pos;
  logic chan_hit;

  always_comb begin
    robbed_pos = (bit_q == BIT_LAST) && rob_frame(32'(frame_q), ROB_PERIOD);
    chan_hit   = chan_en[slot_q];
    marks.mf   = fbit_q && (frame_q == '0);
    // zero-based even frame = one-based odd frame
    marks.dl   = esf_sel && fbit_q && !frame_q[0];
    marks.sig  = !fbit_q && (rbs_en ? robbed_pos : chan_hit);
  end

endmodule

// File: rtl/txmark_gen.sv
module txmark_gen
  import txm_pkg::*;
#(
  parameter int unsigned SLOT_BITS  = BITS_PER_SLOT,
  parameter int unsigned N_E1_SLOTS = E1_SLOTS,
  parameter int unsigned N_E1_FRMS  = E1_MF_FRAMES,
  parameter int unsigned N_T1_CHANS = T1_CHANS,
  parameter int unsigned N_T1_FRMS  = T1_MF_FRAMES,
  parameter int unsigned ROB_PERIOD = ROB_EVERY,
  localparam int unsigned MAX_SLOTS = (N_E1_SLOTS > N_T1_CHANS) ? N_E1_SLOTS : N_T1_CHANS,
  localparam int unsigned MAX_FRMS  = (N_E1_FRMS > N_T1_FRMS) ? N_E1_FRMS : N_T1_FRMS,
  localparam int unsigned BIT_W     = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS),
  localparam int unsigned FRM_W     = $clog2(MAX_FRMS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_en,
  input  logic                  mode_t1,
  input  logic                  esf_sel,
  input  logic                  rbs_en,
  input  logic [N_E1_SLOTS-1:0] slot_en,
  input  logic [SA_COUNT-1:0]   sa_en,
  output logic                  mf_begin,
  output logic                  sig_mark,
  output logic                  dl_mark
);

  // named internal events, visible to the bound checker
  logic              mode_q;
  logic              mode_flip;
  logic [BIT_W-1:0]  cur_bit;
  logic [SLOT_W-1:0] cur_slot;
  logic [FRM_W-1:0]  cur_frame;
  logic              cur_fbit;
  logic              frame_end;
  logic              mf_end;
  marks_t            e1_marks;
  marks_t            t1_marks;
  marks_t            sel_marks;

  always_ff @(posedge clk) begin
    mode_q <= mode_t1;
  end

  assign mode_flip = !rst && (mode_t1 != mode_q);

  txm_pos_counter #(
    .SLOT_BITS (SLOT_BITS),
    .N_E1_SLOTS(N_E1_SLOTS),
    .N_E1_FRMS (N_E1_FRMS),
    .N_T1_CHANS(N_T1_CHANS),
    .N_T1_FRMS (N_T1_FRMS)
  ) u_pos (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .t1        (mode_q),
    .restart   (mode_flip),
    .restart_t1(mode_t1),
    .bit_q     (cur_bit),
    .slot_q    (cur_slot),
    .frame_q   (cur_frame),
    .fbit_q    (cur_fbit),
    .frame_end (frame_end),
    .mf_end    (mf_end)
  );

  txm_e1_decode #(
    .SLOT_BITS(SLOT_BITS),
    .N_SLOTS  (N_E1_SLOTS),
    .BIT_W    (BIT_W),
    .SLOT_W   (SLOT_W),
    .FRM_W    (FRM_W)
  ) u_e1 (
    .bit_q  (cur_bit),
    .slot_q (cur_slot),
    .frame_q(cur_frame),
    .slot_en(slot_en),
    .sa_en  (sa_en),
    .marks  (e1_marks)
  );

  txm_t1_decode #(
    .SLOT_BITS (SLOT_BITS),
    .N_CHANS   (N_T1_CHANS),
    .ROB_PERIOD(ROB_PERIOD),
    .BIT_W     (BIT_W),
    .SLOT_W    (SLOT_W),
    .FRM_W     (FRM_W)
  ) u_t1 (
    .bit_q  (cur_bit),
    .slot_q (cur_slot),
    .frame_q(cur_frame),
    .fbit_q (cur_fbit),
    .chan_en(slot_en[N_T1_CHANS-1:0]),
    .esf_sel(esf_sel),
    .rbs_en (rbs_en),
    .marks  (t1_marks)
  );

  assign sel_marks = mode_q ? t1_marks : e1_marks;
  assign mf_begin  = sel_marks.mf;
  assign sig_mark  = sel_marks.sig;
  assign dl_mark   = sel_marks.dl;

endmodule

// File: rtl/txm_checker.sv
module txm_checker #(
  parameter int unsigned BIT_W     = 3,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned FRM_W     = 5,
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned SA_FIRST  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              esf_sel,
  input logic              rbs_en,
  input logic              mode_q,
  input logic              mode_flip,
  input logic [BIT_W-1:0]  cur_bit,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [FRM_W-1:0]  cur_frame,
  input logic              cur_fbit,
  input logic              mf_end,
  input logic              mf_begin,
  input logic              sig_mark,
  input logic              dl_mark
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);
  localparam logic [BIT_W-1:0] SA_LOW   = BIT_W'(SA_FIRST);

  assert_mf_one_bit_R1: assert property (@(posedge clk) disable iff (rst)
    (mf_begin && bit_en && !mode_flip) |=> !mf_begin);

  assert_mf_after_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (mf_end && !mode_flip) |=> mf_begin);

  assert_e1_dl_window_R2: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && dl_mark) |-> (cur_slot == '0 && cur_frame[0] && cur_bit >= SA_LOW));

  assert_t1_dl_fbit_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q && dl_mark) |-> (esf_sel && cur_fbit));

  assert_robbed_lsb_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && rbs_en && sig_mark) |-> (!cur_fbit && cur_bit == BIT_LAST));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !mode_flip) |=> $stable({cur_bit, cur_slot, cur_frame, cur_fbit}));

  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !mode_flip) |=> !$stable({cur_bit, cur_slot, cur_frame, cur_fbit}));

  assert_reset_start_R8: assert property (@(posedge clk)
    rst |=> mf_begin);

  assert_mode_restart_R9: assert property (@(posedge clk) disable iff (rst)
    mode_flip |=> mf_begin);

endmodule

bind txmark_gen txm_checker #(
  .BIT_W    (BIT_W),
  .SLOT_W   (SLOT_W),
  .FRM_W    (FRM_W),
  .SLOT_BITS(SLOT_BITS),
  .SA_FIRST (txm_pkg::SA_FIRST0)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_en   (bit_en),
  .esf_sel  (esf_sel),
  .rbs_en   (rbs_en),
  .mode_q   (mode_q),
  .mode_flip(mode_flip),
  .cur_bit  (cur_bit),
  .cur_slot (cur_slot),
  .cur_frame(cur_frame),
  .cur_fbit (cur_fbit),
  .mf_end   (mf_end),
  .mf_begin (mf_begin),
  .sig_mark (sig_mark),
  .dl_mark  (dl_mark)
);

// File: tb/sim_txmark_gen.sv
module sim_txmark_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        mode_t1 = 1'b0;
  logic        esf_sel = 1'b0;
  logic        rbs_en = 1'b0;
  logic [31:0] slot_en = '0;
  logic [4:0]  sa_en = '0;
  logic        mf_begin, sig_mark, dl_mark;

  int unsigned n_bits = 0;   // bits sent since last restart
  int          n_checks = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;     // 50 MHz

  txmark_gen u0 (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .mode_t1 (mode_t1),
    .esf_sel (esf_sel),
    .rbs_en  (rbs_en),
    .slot_en (slot_en),
    .sa_en   (sa_en),
    .mf_begin(mf_begin),
    .sig_mark(sig_mark),
    .dl_mark (dl_mark)
  );

  // expected {mf, sig, dl} for bit number n, one-based frame/bit numbering
  function automatic logic [2:0] ref_marks(int unsigned n, logic t1, logic esf,
                                           logic rbs, logic [31:0] se, logic [4:0] sa);
    int unsigned fr, ts, b, p;
    logic mf, sig, dl;
    mf = 0; sig = 0; dl = 0;
    if (!t1) begin
      fr = (n / 256) % 16 + 1;
      ts = (n / 8) % 32;
      b  = n % 8 + 1;
      mf  = (fr == 1) && (ts == 0) && (b == 1);
      sig = se[ts];
      dl  = (ts == 0) && (fr % 2 == 0) && (b >= 4) && sa[b-4];
    end else begin
      fr = (n / 193) % 24 + 1;
      p  = n % 193;
      if (p == 0) begin
        mf = (fr == 1);
        dl = esf && (fr % 2 == 1);
      end else begin
        b   = (p - 1) % 8 + 1;
        sig = rbs ? ((b == 8) && (fr % 6 == 0)) : se[(p - 1) / 8];
      end
    end
    return {mf, sig, dl};
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at bit %0d mode %0d: got %b expected %b",
               req, n_bits, mode_t1, got, exp);
    end
  endtask

  task automatic check_now();
    logic [2:0] e;
    e = ref_marks(n_bits, mode_t1, esf_sel, rbs_en, slot_en, sa_en);
    chk(mf_begin, e[2], "R1");
    chk(sig_mark, e[1], mode_t1 ? (rbs_en ? "R6" : "R5") : "R5/R10");
    chk(dl_mark,  e[0], mode_t1 ? "R4" : "R2/R3/R10");
  endtask

  // random-gap stepping: covers R7 hold and advance
  task automatic run(input int cycles, input int en_pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now();
      bit_en = (($urandom % 100) < en_pct);
      @(posedge clk);
      if (bit_en) n_bits++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    bit_en = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_bits = 0;
    chk(mf_begin, 1'b1, "R8");
    check_now();
  endtask

  task automatic flip_mode(input logic to_t1);
    @(negedge clk);
    bit_en = 1'b1;             // absorbed by the restart (R9)
    mode_t1 = to_t1;
    @(posedge clk);
    n_bits = 0;
    @(negedge clk);
    bit_en = 1'b0;
    chk(mf_begin, 1'b1, "R9");
    check_now();
  endtask

  task automatic hold_check();
    logic [2:0] snap;
    @(negedge clk);
    bit_en = 1'b0;
    snap = {mf_begin, sig_mark, dl_mark};
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(mf_begin, snap[2], "R7");
    chk(sig_mark, snap[1], "R7");
    chk(dl_mark,  snap[0], "R7");
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    // E1, T1-only controls set to show they do nothing (R10)
    mode_t1 = 1'b0; esf_sel = 1'b1; rbs_en = 1'b1;
    slot_en = $urandom; sa_en = 5'b11111;
    do_reset();
    run(9000, 80);
    sa_en = 5'($urandom); slot_en = $urandom; esf_sel = 1'b0;
    run(5000, 100);
    // single Sa enables expose ordering (R3)
    for (int k = 0; k < 5; k++) begin
      sa_en = 5'(1 << k);
      rbs_en = k[0];
      run(600, 100);
    end
    // T1 extended superframe, channel signaling (R4, R5)
    flip_mode(1'b1);
    esf_sel = 1'b1; rbs_en = 1'b0; slot_en = $urandom;
    run(6000, 90);
    // robbed bits (R6)
    rbs_en = 1'b1;
    run(6000, 100);
    // no data-link without extended superframe (R4)
    esf_sel = 1'b0; slot_en = 32'h00FF_0F0F;
    run(2500, 100);
    rbs_en = 1'b0;
    run(2500, 100);
    // restarts mid-multiframe (R8, R9)
    esf_sel = 1'b1;
    run(777, 100);
    do_reset();
    run(500, 100);
    flip_mode(1'b0);
    hold_check();
    run(1500, 50);
    flip_mode(1'b1);
    run(400, 100);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule